// File: doc/BRIEF.md
# Command Response Halfword Queue

This block sits beside the command line of an SD/MMC host controller. After a command has gone out, it watches the serial command line for the card's reply. The reply is a frame that starts with a zero bit. The block shifts it in most significant bit first, one bit for each bit strobe. It packs the bits into 16-bit halfwords and places them in a small queue. Software then drains the queue with one register read per halfword.

The response format is chosen when a command starts:

- A short reply is 48 bits and leaves three halfwords in the queue.
- A long reply is 136 bits and leaves nine halfwords. The last of these is padded with zeros, so that software can rebuild 32-bit words that straddle byte boundaries.

A 7-bit CRC is checked where the format carries one. A reply that never starts within a bounded number of bit times is flagged as a timeout. Both outcomes set a response-end status bit and raise a one-cycle response-end event.

The controlling state machine has four states:

- IDLE: nothing expected.
- WAIT: hunting for the start bit.
- RECV: shifting the frame in.
- DONE: the reply or the timeout has been recorded.

Its transitions are:

- start (any state to WAIT on a command start with a valid format, or to IDLE on a command start with no response).
- found (WAIT to RECV on a zero bit).
- expire (WAIT to DONE when the timeout limit is reached).
- finish (RECV to DONE on the final bit).

Top module: `rsp_hwq`

## Requirements
- R1: After reset, the status word is zero, the read data is zero and the response-end event is low.
- R2: Format code 1 and code 3 expect a 48-bit reply, and code 2 expects a 136-bit reply. Code 0 and codes 4 to 7 expect nothing: the command line is ignored, the status stays zero and the queue stays empty.
- R3: Bits are taken only on a bit strobe. Line-high strobes before the first zero bit are skipped, and that zero start bit becomes bit 15 of the first halfword.
- R4: A 48-bit reply yields three halfwords holding the frame in order. The 32-bit payload is the low byte of the first halfword, then all of the second, then the high byte of the third.
- R5: A 136-bit reply yields nine halfwords holding the frame in order. The low 8 bits of the ninth halfword are zero.
- R6: The read data always shows the oldest unread halfword, and a read strobe removes it. A read of the empty queue returns zero and leaves the queue empty.
- R7: In the cycle after the final bit of a reply is strobed, status bit 11 is set and the response-end event is high for exactly one cycle.
- R8: The CRC is x^7+x^3+1, starting from zero. For code 1 it covers frame bits 1 to 40, and for code 2 it covers frame bits 9 to 128. A mismatch with the seven bits ahead of the end bit sets status bit 5. Code 3 never sets bit 5.
- R9: A timeout is declared when TIMEOUT_BITS line-high strobes arrive while waiting for the start bit. It sets status bits 1 and 11 and pulses the event, and the queue stays empty. One strobe fewer does not time out.
- R10: A command start clears the queue and the status and aborts any capture in progress.
- R11: Status bits other than 11, 5 and 1 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle pulse: a new command begins |
| rsp_fmt | input | 3 | Response format code, sampled with cmd_start |
| bit_stb | input | 1 | One-cycle strobe: cmd_in holds a valid line bit |
| cmd_in | input | 1 | Serial command line level |
| rd_en | input | 1 | Read strobe that removes the head halfword |
| rd_data | output | 16 | Head halfword, or zero when the queue is empty |
| sts | output | 16 | Status: bit 11 end, bit 5 CRC error, bit 1 timeout |
| rsp_end_evt | output | 1 | One-cycle response-end event |

## Verification
The bench builds the block with TIMEOUT_BITS set to 20 instead of the default 64. This keeps the timeout corner short, so both exactly-at-limit and one-below-limit runs of idle strobes fit easily into each test. The frame lengths stay at 48 and 136 bits. Random replies therefore cover every packing boundary, including the padded ninth halfword. Random gaps between strobes, corrupted CRC fields and a command start in the middle of a frame are used to exercise the abort and clear paths.

// File: rtl/rsp_hwq_pkg.sv
package rsp_hwq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RECV,
        ST_DONE
    } rx_state_t;

    localparam logic [2:0] FMT_NONE  = 3'd0;
    localparam logic [2:0] FMT_SHORT = 3'd1;
    localparam logic [2:0] FMT_LONG  = 3'd2;
    localparam logic [2:0] FMT_NOCRC = 3'd3;

    localparam int STS_END_BIT = 11;
    localparam int STS_CRC_BIT = 5;
    localparam int STS_TO_BIT  = 1;

    function automatic logic fmt_valid(input logic [2:0] f);
        return (f == FMT_SHORT) || (f == FMT_LONG) || (f == FMT_NOCRC);
    endfunction
endpackage

// File: rtl/rsp_hwq_crc.sv
module rsp_hwq_crc #(
    parameter int          CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY = 7'h09
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic calc_en,
    input  logic rx_en,
    input  logic bit_i,
    output logic match_o
);
    logic [CRC_W-1:0] calc_q;
    logic [CRC_W-1:0] rx_q;
    logic             fb;

    assign fb = calc_q[CRC_W-1] ^ bit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            calc_q <= '0;
            rx_q   <= '0;
        end else if (clr) begin
            calc_q <= '0;
            rx_q   <= '0;
        end else begin
            if (calc_en)
                calc_q <= {calc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
            if (rx_en)
                rx_q <= {rx_q[CRC_W-2:0], bit_i};
        end
    end

    assign match_o = (calc_q == rx_q);
endmodule

// File: rtl/rsp_hwq_fifo.sv
module rsp_hwq_fifo #(
    parameter int DEPTH = 9,
    parameter int W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] lvl_q;
    logic          do_wr, do_rd;

    assign do_wr = wr_en && (lvl_q != LW'(DEPTH));
    assign do_rd = rd_en && (lvl_q != '0);

    always_ff @(posedge clk) begin
        if (do_wr && !clr)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            if (do_wr)
                wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd)
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_wr && !do_rd)
                lvl_q <= lvl_q + 1'b1;
            else if (do_rd && !do_wr)
                lvl_q <= lvl_q - 1'b1;
        end
    end

    assign rd_data = (lvl_q != '0) ? mem[rd_ptr] : '0;
    assign level   = lvl_q;
endmodule

// File: rtl/rsp_hwq_rx.sv
module rsp_hwq_rx
    import rsp_hwq_pkg::*;
#(
    parameter int TIMEOUT_BITS = 64,
    parameter int SHORT_BITS   = 48,
    parameter int LONG_BITS    = 136,
    parameter int CRC_W        = 7,
    parameter int LONG_HDR     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [2:0]  rsp_fmt,
    input  logic        bit_stb,
    input  logic        cmd_in,
    input  logic        crc_match,
    output logic        wr_en,
    output logic [15:0] wr_data,
    output logic        crc_clr,
    output logic        crc_calc,
    output logic        crc_rx,
    output logic        end_flag,
    output logic        crc_flag,
    output logic        to_flag,
    output logic        end_evt
);
    localparam int BW  = $clog2(LONG_BITS + 1);
    localparam int TW  = $clog2(TIMEOUT_BITS + 1);

    rx_state_t state, state_nx;

    logic [BW-1:0] bcnt;
    logic [TW-1:0] to_cnt;
    logic [15:0]   sr;
    logic [3:0]    hcnt;
    logic          long_q, chk_q;

    logic          take, last, expire;
    logic [BW-1:0] bnum, flen, crc_lo, crc_hi;
    logic [15:0]   sr_next;

    assign flen    = long_q ? BW'(LONG_BITS) : BW'(SHORT_BITS);
    assign crc_lo  = long_q ? BW'(LONG_HDR + 1) : BW'(1);
    assign crc_hi  = flen - BW'(CRC_W + 1);
    assign bnum    = bcnt + 1'b1;
    assign sr_next = {sr[14:0], cmd_in};

    assign take   = bit_stb && !cmd_start &&
                    ((state == ST_RECV) || (state == ST_WAIT && !cmd_in));
    assign last   = take && (bnum == flen);
    assign expire = bit_stb && !cmd_start && (state == ST_WAIT) && cmd_in &&
                    (to_cnt == TW'(TIMEOUT_BITS - 1));

    assign wr_en    = take && ((hcnt == 4'd15) || (bnum == flen));
    assign wr_data  = sr_next << (4'd15 - hcnt);
    assign crc_clr  = cmd_start;
    assign crc_calc = take && (bnum >= crc_lo) && (bnum <= crc_hi);
    assign crc_rx   = take && (bnum > crc_hi) && (bnum < flen);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cmd_start) begin
            state_nx = fmt_valid(rsp_fmt) ? ST_WAIT : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_WAIT: begin
                    if (take)        state_nx = ST_RECV;
                    else if (expire) state_nx = ST_DONE;
                end
                ST_RECV: if (last) state_nx = ST_DONE;
                ST_DONE: state_nx = ST_DONE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt     <= '0;
            to_cnt   <= '0;
            sr       <= '0;
            hcnt     <= '0;
            long_q   <= 1'b0;
            chk_q    <= 1'b0;
            end_flag <= 1'b0;
            crc_flag <= 1'b0;
            to_flag  <= 1'b0;
            end_evt  <= 1'b0;
        end else begin
            end_evt <= 1'b0;
            if (cmd_start) begin
                bcnt     <= '0;
                to_cnt   <= '0;
                sr       <= '0;
                hcnt     <= '0;
                long_q   <= (rsp_fmt == FMT_LONG);
                chk_q    <= (rsp_fmt != FMT_NOCRC);
                end_flag <= 1'b0;
                crc_flag <= 1'b0;
                to_flag  <= 1'b0;
            end else if (take) begin
                sr   <= sr_next;
                hcnt <= hcnt + 1'b1;
                bcnt <= bnum;
                if (last) begin
                    end_flag <= 1'b1;
                    crc_flag <= chk_q && !crc_match;
                    end_evt  <= 1'b1;
                end
            end else if (bit_stb && state == ST_WAIT) begin
                to_cnt <= to_cnt + 1'b1;
                if (expire) begin
                    to_flag  <= 1'b1;
                    end_flag <= 1'b1;
                    end_evt  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsp_hwq.sv
module rsp_hwq
    import rsp_hwq_pkg::*;
#(
    parameter int TIMEOUT_BITS = 64,
    parameter int SHORT_BITS   = 48,
    parameter int LONG_BITS    = 136
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [2:0]  rsp_fmt,
    input  logic        bit_stb,
    input  logic        cmd_in,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic [15:0] sts,
    output logic        rsp_end_evt
);
    localparam int DEPTH = (LONG_BITS + 15) / 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          crc_match, crc_clr, crc_calc, crc_rx;
    logic          fifo_wr;
    logic [15:0]   fifo_wdata;
    logic [LW-1:0] fifo_level;
    logic          end_flag, crc_flag, to_flag;

    rsp_hwq_rx #(
        .TIMEOUT_BITS (TIMEOUT_BITS),
        .SHORT_BITS   (SHORT_BITS),
        .LONG_BITS    (LONG_BITS)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .rsp_fmt   (rsp_fmt),
        .bit_stb   (bit_stb),
        .cmd_in    (cmd_in),
        .crc_match (crc_match),
        .wr_en     (fifo_wr),
        .wr_data   (fifo_wdata),
        .crc_clr   (crc_clr),
        .crc_calc  (crc_calc),
        .crc_rx    (crc_rx),
        .end_flag  (end_flag),
        .crc_flag  (crc_flag),
        .to_flag   (to_flag),
        .end_evt   (rsp_end_evt)
    );

    rsp_hwq_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (crc_clr),
        .calc_en (crc_calc),
        .rx_en   (crc_rx),
        .bit_i   (cmd_in),
        .match_o (crc_match)
    );

    rsp_hwq_fifo #(
        .DEPTH (DEPTH),
        .W     (16)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_start),
        .wr_en   (fifo_wr),
        .wr_data (fifo_wdata),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .level   (fifo_level)
    );

    always_comb begin
        sts              = '0;
        sts[STS_END_BIT] = end_flag;
        sts[STS_CRC_BIT] = crc_flag;
        sts[STS_TO_BIT]  = to_flag;
    end
endmodule

// File: rtl/rsp_hwq_chk.sv
module rsp_hwq_chk #(
    parameter int DEPTH = 9
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_start,
    input logic                       rd_en,
    input logic [15:0]                rd_data,
    input logic [15:0]                sts,
    input logic                       rsp_end_evt,
    input logic                       fifo_wr,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    // R7: the event is a single-cycle pulse
    p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_end_evt |=> !rsp_end_evt);

    // R7: the event is accompanied by the end status bit
    p_evt_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_end_evt |-> sts[11]);

    // R6: an empty queue reads as zero
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> (rd_data == 16'h0));

    // R6: reading an empty queue keeps it empty
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fifo_level == '0 && !fifo_wr && !cmd_start) |=> (fifo_level == '0));

    // R5: the queue never holds more than one long reply
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

    // R10: a command start empties the queue and clears status
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (fifo_level == '0 && sts == 16'h0));

    // R9: a timeout leaves no data behind
    p_timeout_nodata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[1]) |-> (fifo_level == '0 && sts[11]));

    // R11: unused status bits stay zero
    p_sts_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts & ~16'h0822) == 16'h0);
endmodule

bind rsp_hwq rsp_hwq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .sts         (sts),
    .rsp_end_evt (rsp_end_evt),
    .fifo_wr     (fifo_wr),
    .fifo_level  (fifo_level)
);

// File: tb/test_rsp_hwq.sv
module test_rsp_hwq;
    localparam int CLK_PERIOD = 10;
    localparam int TO_BITS    = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [2:0]  rsp_fmt = 3'd0;
    logic        bit_stb = 1'b0;
    logic        cmd_in = 1'b1;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [15:0] sts;
    logic        rsp_end_evt;

    int total = 0;
    int bad = 0;
    int evt_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsp_hwq #(.TIMEOUT_BITS(TO_BITS)) i_rsp_hwq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .rsp_fmt     (rsp_fmt),
        .bit_stb     (bit_stb),
        .cmd_in      (cmd_in),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .sts         (sts),
        .rsp_end_evt (rsp_end_evt)
    );

    always @(negedge clk) if (rst_n && rsp_end_evt) evt_cnt++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_of(input logic [143:0] v, input int a, input int b);
        logic [6:0] c = '0;
        for (int k = a; k <= b; k++) begin
            logic fb = c[6] ^ v[144-k];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [15:0] hw_of(input logic [143:0] v, input int k);
        return v[143-16*k -: 16];
    endfunction

    task automatic start_cmd(input logic [2:0] f);
        @(negedge clk);
        cmd_start = 1'b1;
        rsp_fmt = f;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        bit_stb = 1'b1;
        cmd_in = b;
        @(negedge clk);
        bit_stb = 1'b0;
        cmd_in = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic pop(output logic [15:0] hw);
        hw = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // build a frame left-aligned in 144 bits
    function automatic logic [143:0] make_frame(input logic [2:0] f, input logic corrupt);
        logic [143:0] v = '0;
        logic [127:0] body = {$urandom, $urandom, $urandom, $urandom};
        if (f == 3'd2) begin
            v[143:8] = {2'b00, 6'h3f, body[119:0], 7'h00, 1'b1};
            v[15:9]  = crc_of(v, 9, 128) ^ (corrupt ? 7'h11 : 7'h00);
        end else begin
            v[143:96] = {2'b00, body[37:32], body[31:0], 7'h00, 1'b1};
            if (f == 3'd3) v[103:97] = 7'h7f;
            else           v[103:97] = crc_of(v, 1, 40) ^ (corrupt ? 7'h05 : 7'h00);
        end
        return v;
    endfunction

    task automatic run_frame(input logic [2:0] f, input logic corrupt, input int lead, input bit rnd_gap);
        logic [143:0] v;
        logic [15:0]  hw;
        logic [15:0]  got [9];
        int len, nhw, ev0;
        logic [15:0] exp_sts;
        v = make_frame(f, corrupt);
        len = (f == 3'd2) ? 136 : 48;
        nhw = (f == 3'd2) ? 9 : 3;
        start_cmd(f);
        ev0 = evt_cnt;
        for (int i = 0; i < lead; i++) send_bit(1'b1, 0);
        for (int k = 1; k <= len; k++)
            send_bit(v[144-k], (k == len || !rnd_gap) ? 0 : int'($urandom_range(0, 2)));
        // R7: event and end bit visible the cycle after the last strobe
        check("R7 evt at end", {31'd0, rsp_end_evt}, 32'd1);
        exp_sts = 16'h0800;
        if (corrupt && f != 3'd3) exp_sts[5] = 1'b1;
        check("R8 status after reply", {16'd0, sts}, {16'd0, exp_sts});
        @(negedge clk);
        check("R7 evt single", {31'd0, rsp_end_evt}, 32'd0);
        check("R7 evt count", evt_cnt - ev0, 32'd1);
        for (int k = 0; k < nhw; k++) begin
            pop(hw);
            got[k] = hw;
            check((f == 3'd2) ? "R5 long halfword" : "R4 short halfword", {16'd0, hw}, {16'd0, hw_of(v, k)});
        end
        if (f == 3'd2) begin
            check("R5 pad byte zero", {24'd0, got[8][7:0]}, 32'd0);
        end else begin
            check("R4 payload", {got[0][7:0], got[1], got[2][15:8]}, v[135:104]);
        end
        check("R3 start bit is msb", {31'd0, got[0][15]}, 32'd0);
        pop(hw);
        check("R6 empty read zero", {16'd0, hw}, 32'd0);
        pop(hw);
        check("R6 second empty read zero", {16'd0, hw}, 32'd0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] hw;
        logic [143:0] v;
        int ev0;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        check("R1 reset sts", {16'd0, sts}, 32'd0);
        check("R1 reset rd_data", {16'd0, rd_data}, 32'd0);
        check("R1 reset evt", {31'd0, rsp_end_evt}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: each format, clean and corrupted, lead one below timeout
        run_frame(3'd1, 1'b0, TO_BITS - 1, 1'b0);
        run_frame(3'd2, 1'b0, 0, 1'b0);
        run_frame(3'd3, 1'b0, 3, 1'b0);
        run_frame(3'd1, 1'b1, 0, 1'b0);
        run_frame(3'd2, 1'b1, 1, 1'b0);

        // R9: timeout at exactly the limit
        start_cmd(3'd1);
        ev0 = evt_cnt;
        for (int i = 0; i < TO_BITS; i++) send_bit(1'b1, 0);
        check("R9 timeout status", {16'd0, sts}, 32'h0802);
        check("R9 timeout evt", {31'd0, rsp_end_evt}, 32'd1);
        @(negedge clk);
        check("R9 timeout queue empty", {16'd0, rd_data}, 32'd0);
        check("R9 timeout one evt", evt_cnt - ev0, 32'd1);
        send_bit(1'b0, 0);
        check("R9 no capture after timeout", {16'd0, rd_data}, 32'd0);

        // R2: no-response codes ignore the line
        for (int c = 0; c < 2; c++) begin
            start_cmd(c == 0 ? 3'd0 : 3'd5);
            ev0 = evt_cnt;
            v = make_frame(3'd1, 1'b0);
            for (int k = 1; k <= 48; k++) send_bit(v[144-k], 0);
            @(negedge clk);
            check("R2 no-response status", {16'd0, sts}, 32'd0);
            check("R2 no-response queue", {16'd0, rd_data}, 32'd0);
            check("R2 no-response evt", evt_cnt - ev0, 32'd0);
        end

        // R10: unread reply is cleared by a command start
        start_cmd(3'd1);
        v = make_frame(3'd1, 1'b0);
        for (int k = 1; k <= 48; k++) send_bit(v[144-k], 0);
        start_cmd(3'd0);
        check("R10 clear queue", {16'd0, rd_data}, 32'd0);
        check("R10 clear status", {16'd0, sts}, 32'd0);

        // R10: abort in the middle of a frame, then a full reply
        start_cmd(3'd2);
        v = make_frame(3'd2, 1'b0);
        for (int k = 1; k <= 70; k++) send_bit(v[144-k], 0);
        run_frame(3'd1, 1'b0, 2, 1'b1);

        // random mix
        for (int n = 0; n < 30; n++) begin
            logic [2:0] f = 3'($urandom_range(1, 3));
            run_frame(f, 1'($urandom_range(0, 1)), int'($urandom_range(0, TO_BITS - 1)), 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule